// File: doc/BRIEF.md
# DMA Descriptor-Chain Status Controller

This block is the control and status core of a single DMA channel. Software programs a mode word, writes the address of a first segment descriptor, and issues a start command. In direct mode the channel runs exactly one segment. In chaining mode it fetches the link word of the current descriptor over a request/acknowledge port, then hands the segment to an external data mover through a one-cycle start pulse, and waits for a done pulse.

When a non-final segment completes, the captured link is promoted into the current-descriptor register and the next link is fetched. The chain stops after the descriptor whose link word carries the last-descriptor bit. A small status word holds three write-1-to-clear flags (segment end, chain end, transfer error) and a read-only busy bit. An interrupt line reflects every enabled flag. A halt command stops the channel cleanly at the next segment boundary. A later start resumes from the current-descriptor register.

The register window has four words. Word 0 is the mode word: bit 0 selects chaining, bit 1 enables the chain-end interrupt, and bit 2 masks transfer errors. Word 1 is the status word. Word 2 is the current descriptor. A write to word 3 is a command: bit 0 starts the channel and bit 1 halts it. A read of word 3 returns the captured link.

A fetched link word has the same layout as the current-descriptor register:
- bits 31..5 hold the next descriptor's address;
- bit 4 is that descriptor's snoop flag;
- bit 3 is that descriptor's segment-interrupt enable;
- bit 0, when set, marks the descriptor just fetched as the last of the chain.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset every readable register (words 0 to 3) reads zero and `irq` is low.
- R2: The status word has transfer error at bit 7, busy at bit 2, segment-end at bit 1 and chain-end at bit 0. All other bits read zero, and writing ones to a clear status word sets nothing.
- R3: Writing 1 to a set flag bit in the status word clears that flag. Writing 0 leaves it unchanged.
- R4: In chaining mode the channel fetches from the 32-byte-aligned address in current-descriptor bits 31..5. After each non-final segment it copies link bits 31..3 into the current-descriptor register and fetches from the new address. Descriptors are fetched in link order.
- R5: The chain ends after the segment whose fetched link has bit 0 set. The current-descriptor register then still holds that last descriptor.
- R6: In direct mode (mode bit 0 clear) a start runs exactly one segment with no descriptor fetch.
- R7: A completed segment sets status bit 1 only when bit 3 of the current-descriptor register was set for that segment.
- R8: Completion of the last segment (chaining) or of the single segment (direct) sets status bit 0 only when mode bit 1 is set.
- R9: A done pulse with `moverErr` high ends the channel with no promotion and no completion flag. It sets status bit 7 only when mode bit 2 is clear.
- R10: Busy (status bit 2) is set by a start from idle. It is cleared by chain end, by an error, or by a halt.
- R11: A halt command while busy stops the channel after the current non-final segment, with the promotion done and status bit 0 left clear. A later start continues the chain from the current-descriptor register.
- R12: `irq` is high while transfer error is set with mode bit 2 clear, or segment-end is set, or chain-end is set with mode bit 1 set. It stays high until software clears the flag.
- R13: While busy, a start command and writes to the current-descriptor register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on regAddr) |
| fetchReq | output | 1 | Descriptor link fetch request, held until acknowledged |
| fetchAddr | output | 32 | Address of the descriptor being fetched |
| fetchAck | input | 1 | Fetch acknowledge, fetchData valid |
| fetchData | input | 32 | Fetched link word |
| moverStart | output | 1 | One-cycle pulse starting a segment |
| moverDone | input | 1 | One-cycle pulse ending a segment |
| moverErr | input | 1 | Qualifies moverDone as an errored segment |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the data mover answers each start pulse with exactly one done pulse. The done pulse comes at least one cycle after the start, and `moverErr` is only meaningful together with it. They also assume that fetch acknowledges arrive only while a fetch is requested.

The bench's responder follows these rules by construction. It acknowledges only a raised request, in the same cycle that it sees it. It arms a done countdown when it sees the start pulse and fires the done pulse on a later cycle. Random chains keep their descriptors in distinct aligned slots, so every link points to a unique address.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int REG_W   = 32;
  localparam int ALIGN_W = 5;
  localparam int RADDR_W = 2;

  localparam logic [RADDR_W-1:0] A_MODE = 2'd0;
  localparam logic [RADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [RADDR_W-1:0] A_CUR  = 2'd2;
  localparam logic [RADDR_W-1:0] A_CMD  = 2'd3;

  localparam int M_CHAIN   = 0;
  localparam int M_EOTEN   = 1;
  localparam int M_ERRMASK = 2;

  localparam int S_TE   = 7;
  localparam int S_BUSY = 2;
  localparam int S_EOS  = 1;
  localparam int S_EOC  = 0;

  localparam int D_SNOOP = 4;
  localparam int D_SEGEN = 3;
  localparam int D_LAST  = 0;

  localparam logic [REG_W-1:0] CUR_MASK = {REG_W{1'b1}} << D_SEGEN;
  localparam logic [REG_W-1:0] NXT_MASK = CUR_MASK | (REG_W'(1) << D_LAST);

  typedef struct packed {
    logic loadNext;
    logic promote;
    logic segDone;
    logic chainDone;
    logic errHit;
  } ctlStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_KICK, ST_WAIT} chanState_t;
endpackage

// File: rtl/dma_chain_path.sv
module dma_chain_path
  import dma_chain_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [RADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]   regWrData,
  input  logic [REG_W-1:0]   fetchData,
  input  ctlStrobe_t         strobe,
  input  logic               busy,
  output logic               chainMode,
  output logic               isLast,
  output logic               errFlag,
  output logic [REG_W-1:0]   regRdData,
  output logic [REG_W-1:0]   fetchAddr,
  output logic               irq
);
  logic [REG_W-1:0] curQ, nxtQ;
  logic chainQ, eotEnQ, maskQ;
  logic teQ, eosQ, eocQ;
  logic wrMode, wrStat, wrCur;

  assign wrMode = regWrEn && (regAddr == A_MODE);
  assign wrStat = regWrEn && (regAddr == A_STAT);
  assign wrCur  = regWrEn && (regAddr == A_CUR) && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curQ <= '0;
      nxtQ <= '0;
      chainQ <= 1'b0;
      eotEnQ <= 1'b0;
      maskQ <= 1'b0;
      teQ <= 1'b0;
      eosQ <= 1'b0;
      eocQ <= 1'b0;
    end else begin
      if (wrMode) begin
        chainQ <= regWrData[M_CHAIN];
        eotEnQ <= regWrData[M_EOTEN];
        maskQ  <= regWrData[M_ERRMASK];
      end
      if (strobe.promote) curQ <= nxtQ & CUR_MASK;
      else if (wrCur)     curQ <= regWrData & CUR_MASK;
      if (strobe.loadNext) nxtQ <= fetchData & NXT_MASK;
      teQ  <= (teQ  & ~(wrStat & regWrData[S_TE]))  | (strobe.errHit & ~maskQ);
      eosQ <= (eosQ & ~(wrStat & regWrData[S_EOS])) | (strobe.segDone & curQ[D_SEGEN]);
      eocQ <= (eocQ & ~(wrStat & regWrData[S_EOC])) | (strobe.chainDone & eotEnQ);
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      A_MODE: begin
        regRdData[M_CHAIN]   = chainQ;
        regRdData[M_EOTEN]   = eotEnQ;
        regRdData[M_ERRMASK] = maskQ;
      end
      A_STAT: begin
        regRdData[S_TE]   = teQ;
        regRdData[S_BUSY] = busy;
        regRdData[S_EOS]  = eosQ;
        regRdData[S_EOC]  = eocQ;
      end
      A_CUR:   regRdData = curQ;
      default: regRdData = nxtQ;
    endcase
  end

  assign chainMode = chainQ;
  assign isLast    = nxtQ[D_LAST];
  assign errFlag   = teQ;
  assign fetchAddr = {curQ[REG_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
  assign irq       = (teQ & ~maskQ) | eosQ | (eocQ & eotEnQ);
endmodule

// File: rtl/dma_chain_fsm.sv
module dma_chain_fsm
  import dma_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startCmd,
  input  logic       haltCmd,
  input  logic       chainMode,
  input  logic       isLast,
  input  logic       fetchAck,
  input  logic       moverDone,
  input  logic       moverErr,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       fetchReq,
  output logic       moverStart
);
  chanState_t stateQ, stateD;
  logic haltPend;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    case (stateQ)
      ST_IDLE:  if (startCmd) stateD = chainMode ? ST_FETCH : ST_KICK;
      ST_FETCH: if (fetchAck) begin
        strobe.loadNext = 1'b1;
        stateD = ST_KICK;
      end
      ST_KICK:  stateD = ST_WAIT;
      ST_WAIT:  if (moverDone) begin
        if (moverErr) begin
          strobe.errHit = 1'b1;
          stateD = ST_IDLE;
        end else begin
          strobe.segDone = 1'b1;
          if (!chainMode || isLast) begin
            strobe.chainDone = 1'b1;
            stateD = ST_IDLE;
          end else begin
            strobe.promote = 1'b1;
            stateD = (haltPend || haltCmd) ? ST_IDLE : ST_FETCH;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      haltPend <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_IDLE) haltPend <= 1'b0;
      else if (haltCmd)      haltPend <= 1'b1;
    end
  end

  assign busy       = (stateQ != ST_IDLE);
  assign fetchReq   = (stateQ == ST_FETCH);
  assign moverStart = (stateQ == ST_KICK);
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [RADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  output logic               fetchReq,
  output logic [REG_W-1:0]   fetchAddr,
  input  logic               fetchAck,
  input  logic [REG_W-1:0]   fetchData,
  output logic               moverStart,
  input  logic               moverDone,
  input  logic               moverErr,
  output logic               irq
);
  ctlStrobe_t strobe;
  logic busyNow, chainMode, isLast, errFlag, startCmd, haltCmd;

  assign startCmd = regWrEn && (regAddr == A_CMD) && regWrData[0];
  assign haltCmd  = regWrEn && (regAddr == A_CMD) && regWrData[1];

  dma_chain_fsm u_fsm (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .haltCmd(haltCmd),
    .chainMode(chainMode), .isLast(isLast), .fetchAck(fetchAck),
    .moverDone(moverDone), .moverErr(moverErr), .strobe(strobe),
    .busy(busyNow), .fetchReq(fetchReq), .moverStart(moverStart)
  );

  dma_chain_path u_path (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .fetchData(fetchData), .strobe(strobe),
    .busy(busyNow), .chainMode(chainMode), .isLast(isLast),
    .errFlag(errFlag), .regRdData(regRdData), .fetchAddr(fetchAddr), .irq(irq)
  );
endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk (
  input logic clk,
  input logic rstN,
  input logic startCmd,
  input logic regWrEn,
  input logic busy,
  input logic errFlag,
  input logic fetchReq,
  input logic fetchAck,
  input logic moverStart,
  input logic moverDone,
  input logic moverErr,
  input logic irq
);
  // R10: a start from idle makes the channel busy
  a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startCmd) |=> busy);

  // R4: a fetch request is held until it is acknowledged
  a_r4_fetch_held: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !fetchAck) |=> fetchReq);

  // R13: segments only start while the channel is busy
  a_r13_kick_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    moverStart |-> busy);

  // R9: an errored done ends the channel
  a_r9_error_stops: assert property (@(posedge clk) disable iff (!rstN)
    (busy && moverDone && moverErr) |=> !busy);

  // R9: the transfer error flag only rises after an errored done
  a_r9_te_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(moverDone && moverErr));

  // R12: the interrupt holds while software writes nothing
  a_r12_irq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !regWrEn) |=> irq);

  // R4: fetching and segment start never overlap
  a_r4_fetch_kick_apart: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fetchReq, moverStart}));
endmodule

bind dma_chain_ctrl dma_chain_chk u_chk (
  .clk(clk), .rstN(rstN), .startCmd(startCmd), .regWrEn(regWrEn),
  .busy(busyNow), .errFlag(errFlag), .fetchReq(fetchReq), .fetchAck(fetchAck),
  .moverStart(moverStart), .moverDone(moverDone), .moverErr(moverErr), .irq(irq)
);

// File: tb/sim_dma_chain_ctrl.sv
module sim_dma_chain_ctrl;
  import dma_chain_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, regWrEn, fetchReq, fetchAck, moverStart, moverDone, moverErr, irq;
  logic [1:0] regAddr;
  logic [31:0] regWrData, regRdData, fetchAddr, fetchData;

  dma_chain_ctrl u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .fetchReq(fetchReq),
    .fetchAddr(fetchAddr), .fetchAck(fetchAck), .fetchData(fetchData),
    .moverStart(moverStart), .moverDone(moverDone), .moverErr(moverErr), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  logic [31:0] linkTab [8];
  logic [31:0] fetchLog [16];
  int fetchCnt = 0;
  int segIdx = 0;
  int errAt = -1;
  int fixDelay = 0;
  bit rndDelay = 1'b0;
  bit pend = 1'b0;
  int cnt = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // external memory and data mover model
  initial begin
    fetchAck = 0; fetchData = 0; moverDone = 0; moverErr = 0;
    forever begin
      @(negedge clk);
      fetchAck = 0; moverDone = 0; moverErr = 0;
      if (rstN && fetchReq) begin
        fetchAck = 1;
        fetchData = linkTab[fetchAddr[7:5]];
        if (fetchCnt < 16) fetchLog[fetchCnt] = fetchAddr;
        fetchCnt++;
      end
      if (pend) begin
        if (cnt == 0) begin
          moverDone = 1;
          moverErr = ((segIdx - 1) == errAt);
          pend = 0;
        end else cnt--;
      end else if (rstN && moverStart) begin
        pend = 1;
        cnt = rndDelay ? $urandom_range(0, 3) : fixDelay;
        segIdx++;
      end
    end
  end

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0; regWrData = 0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    do regRead(A_STAT, s); while (s[2]);
  endtask

  task automatic prep();
    fetchCnt = 0; segIdx = 0;
    regWrite(A_STAT, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] addrs [8];
    logic [31:0] expCur [8];
    bit segs [8];
    void'($urandom(32'd4711));
    rstN = 0; regWrEn = 0; regAddr = 0; regWrData = 0;
    for (int i = 0; i < 8; i++) linkTab[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), rd);
      check("R1 reset register", rd, 32'h0);
    end
    check("R1 reset irq", {31'b0, irq}, 32'h0);

    // R2 writing ones to clear status sets nothing
    regWrite(A_STAT, 32'hFFFF_FFFF);
    regRead(A_STAT, rd);
    check("R2 status no set by write", rd, 32'h0);

    // R6 R7 R8 direct mode with segment enable and chain-end enable
    fixDelay = 4; rndDelay = 0; errAt = -1;
    regWrite(A_MODE, 32'h2);
    regWrite(A_CUR, 32'h0000_0448);
    prep();
    regWrite(A_CMD, 32'h1);
    regRead(A_STAT, rd);
    check("R10 busy after start", rd, 32'h4);
    waitIdle();
    regRead(A_STAT, rd);
    check("R6 R7 R8 direct status", rd, 32'h3);
    check("R6 direct no fetch", 32'(fetchCnt), 32'd0);
    check("R6 direct one segment", 32'(segIdx), 32'd1);
    check("R12 irq set", {31'b0, irq}, 32'h1);
    repeat (5) @(negedge clk);
    check("R12 irq held", {31'b0, irq}, 32'h1);
    regWrite(A_STAT, 32'h2);
    regRead(A_STAT, rd);
    check("R3 clear segment flag only", rd, 32'h1);
    check("R12 irq from chain end", {31'b0, irq}, 32'h1);
    regWrite(A_STAT, 32'h1);
    regRead(A_STAT, rd);
    check("R3 clear chain flag", rd, 32'h0);
    check("R12 irq low after clear", {31'b0, irq}, 32'h0);

    // R7 R8 direct with both enables clear
    regWrite(A_MODE, 32'h0);
    regWrite(A_CUR, 32'h0000_0440);
    prep();
    regWrite(A_CMD, 32'h1);
    waitIdle();
    regRead(A_STAT, rd);
    check("R7 R8 gated flags", rd, 32'h0);

    // R11 halt mid-chain then resume
    linkTab[1] = 32'h0000_0040;
    linkTab[2] = 32'h0000_0060;
    linkTab[3] = 32'hDEAD_BEE1;
    regWrite(A_MODE, 32'h3);
    regWrite(A_CUR, 32'h0000_0020);
    prep();
    fixDelay = 6;
    regWrite(A_CMD, 32'h1);
    regWrite(A_CMD, 32'h2);
    waitIdle();
    regRead(A_STAT, rd);
    check("R11 halt no completion", rd, 32'h0);
    regRead(A_CUR, rd);
    check("R11 halt promoted", rd, 32'h0000_0040);
    check("R11 halt fetch count", 32'(fetchCnt), 32'd1);
    regWrite(A_CMD, 32'h1);
    waitIdle();
    regRead(A_STAT, rd);
    check("R11 resumed completion", rd, 32'h1);
    check("R11 resumed fetch count", 32'(fetchCnt), 32'd3);
    check("R4 resumed fetch order", fetchLog[1], 32'h40);
    check("R4 resumed fetch order", fetchLog[2], 32'h60);
    regRead(A_CUR, rd);
    check("R5 last descriptor kept", rd, 32'h0000_0060);
    regRead(A_CMD, rd);
    check("R4 link register", rd, 32'hDEAD_BEE1 & NXT_MASK);

    // R13 writes and start ignored while busy
    regWrite(A_CUR, 32'h0000_0020);
    prep();
    fixDelay = 10;
    regWrite(A_CMD, 32'h1);
    regWrite(A_CUR, 32'h0ABC_0008);
    regRead(A_CUR, rd);
    check("R13 current write ignored", rd, 32'h0000_0020);
    regWrite(A_CMD, 32'h1);
    waitIdle();
    check("R13 restart ignored", 32'(fetchCnt), 32'd3);
    check("R13 segments run", 32'(segIdx), 32'd3);

    // R9 directed error with mask clear and set
    regWrite(A_STAT, 32'hFF);
    for (int m = 0; m < 2; m++) begin
      regWrite(A_MODE, 32'h3 | (32'(m) << 2));
      regWrite(A_CUR, 32'h0000_0020);
      prep();
      errAt = 1;
      regWrite(A_CMD, 32'h1);
      waitIdle();
      regRead(A_STAT, rd);
      check("R9 error status", rd, (m == 0) ? 32'h80 : 32'h0);
      regRead(A_CUR, rd);
      check("R9 no promotion on error", rd, 32'h0000_0040);
      check("R12 irq on error", {31'b0, irq}, (m == 0) ? 32'h1 : 32'h0);
    end

    // R4 R5 R7 R8 R9 random chains
    rndDelay = 1;
    for (int it = 0; it < 40; it++) begin
      int len, st, n;
      bit eotEn, mask, errHit, eos, same;
      logic [31:0] expStat;
      len = $urandom_range(1, 6);
      st = $urandom_range(0, 6);
      eotEn = 1'($urandom_range(0, 1));
      mask = 1'($urandom_range(0, 1));
      errAt = ($urandom_range(0, 2) == 0) ? $urandom_range(0, len - 1) : -1;
      for (int k = 0; k < len; k++) begin
        addrs[k] = 32'((((st + k) % 7) + 1) * 32);
        segs[k] = 1'($urandom_range(0, 1));
        expCur[k] = addrs[k] | (32'($urandom_range(0, 1)) << 4) | (32'(segs[k]) << 3);
      end
      for (int k = 0; k < len; k++)
        linkTab[addrs[k][7:5]] = (k == len - 1) ?
          (($urandom() & 32'hFFFF_FF00) | 32'h1) : expCur[k + 1];
      regWrite(A_MODE, {29'b0, mask, eotEn, 1'b1});
      regWrite(A_CUR, expCur[0]);
      prep();
      regWrite(A_CMD, 32'h1);
      waitIdle();
      errHit = (errAt >= 0);
      n = errHit ? errAt + 1 : len;
      eos = 0;
      for (int k = 0; k < (errHit ? errAt : len); k++) eos |= segs[k];
      expStat = (32'(errHit & !mask) << 7) | (32'(eos) << 1) | 32'(!errHit & eotEn);
      regRead(A_STAT, rd);
      check("R7 R8 R9 random status", rd, expStat);
      regRead(A_CUR, rd);
      check("R5 random current", rd, expCur[n - 1]);
      check("R4 random fetch count", 32'(fetchCnt), 32'(n));
      same = 1;
      for (int k = 0; k < n; k++) if (fetchLog[k] !== addrs[k]) same = 0;
      check("R4 random fetch order", {31'b0, same}, 32'h1);
      check("R12 random irq", {31'b0, irq}, {31'b0, |expStat});
      regWrite(A_STAT, 32'h83);
      regRead(A_STAT, rd);
      check("R3 random clear", rd, 32'h0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule